// File: doc/BRIEF.md
# Flash Command Sequencer

This block decodes byte-wide commands arriving on a host write port of a NOR-style flash device and drives an internal write/erase engine. Program and erase both take two writes: a setup byte and then a second write that commits the operation. The sequencer pulses the address and data latch enables, issues a start strobe to the engine, and selects whether host reads return array contents or the status byte.

A running erase can be paused. The sequencer raises a suspend request and holds it until the engine acknowledges. While the erase is paused, only a small set of commands is honoured. A resume command restarts the engine from the count where it stopped. The engine is modelled as a countdown timer whose length comes from a programmable input. A synchronous active-high reset aborts any operation at once.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, status reads 0x80, reads select the array (`rd_is_status`=0), and every engine strobe and latch enable is low.
- R2: In idle, 0x70 selects status reads and 0xFF selects array reads. Any code that is not recognised, including 0xD0, leaves the read mode and the status unchanged.
- R3: In idle, either 0x40 or 0x10 arms a program. The next write pulses `addr_le`, `data_le` and `eng_start` high together for one cycle, with `eng_is_erase`=0, and switches reads to status.
- R4: A program cannot be suspended, and writes during it have no effect (0xB0 raises no request, and 0xFF keeps status reads). Status bit 7 (ready) is 0 until the operation ends. Ready returns high at the edge N+2 cycles after the commit edge, where N is `prog_len`, and a length of 0 counts as 1.
- R5: 0x20 followed directly by 0xD0 starts an erase. The commit pulses `addr_le` and `eng_start` with `eng_is_erase`=1 and leaves `data_le` low. An erase that is never suspended ends with ready high N+2 cycles after the commit, where N is `erase_len`.
- R6: If the write after 0x20 is anything other than 0xD0, no engine start occurs. Status bits 5 (erase error) and 4 (program error) both become 1, reads switch to status, and the next write is decoded as a new command.
- R7: While an erase runs, only 0x70 and 0xB0 are acted on. Any other write produces no latch enable or start, and reads stay on status.
- R8: 0xB0 during an erase raises `eng_susp_req`, which is held until `eng_susp_ack` rises. The cycle after the acknowledge, status bit 6 (suspended) is 1, the request is low, and ready is 1.
- R9: While suspended, 0xFF selects array reads and 0x70 selects status reads, while other codes are ignored. The engine stays frozen however long the suspension lasts.
- R10: 0xD0 while suspended pulses `eng_resume`, clears status bit 6 and drops ready. The erase then finishes after the cycles it had left, plus 2.
- R11: 0x50 in idle clears status bits 5 and 4 and leaves the read mode unchanged.
- R12: A reset during an erase returns the block to its reset state, and a new program is accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, aborts all operations |
| wr_en | input | 1 | Host write strobe, one command per cycle |
| wr_cmd | input | 8 | Command or program-data byte |
| prog_len | input | CNT_W | Engine cycles for a program |
| erase_len | input | CNT_W | Engine cycles for an erase |
| rd_is_status | output | 1 | 1: host reads return status, 0: array |
| addr_le | output | 1 | Address latch enable pulse |
| data_le | output | 1 | Data latch enable pulse |
| eng_start | output | 1 | Engine start strobe |
| eng_is_erase | output | 1 | Operation type qualifying the start strobe |
| eng_susp_req | output | 1 | Suspend request held until acknowledged |
| eng_resume | output | 1 | Resume strobe to the engine |
| eng_susp_ack | output | 1 | Engine reports that it is suspended |
| status | output | 8 | Status byte: bit 7 ready, 6 suspended, 5 erase error, 4 program error |

## Verification
Mode changes, latch enables and strobes are registered, so they show up one cycle after the edge that samples the write. The bench checks them at the falling edge that immediately follows the write. The suspend acknowledge appears one cycle after the request, and the suspended flag one cycle after that. Ready returns at N+2 edges after a commit, or at the remaining count plus 2 after a resume. The bench keeps a posedge counter, records the edge of each relevant write, polls for ready, and compares the edge at which ready first appears against the predicted one.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CMD_W = 8;
    typedef logic [CMD_W-1:0] cmd_t;

    localparam cmd_t CMD_READ_ARRAY  = 8'hFF;
    localparam cmd_t CMD_READ_STATUS = 8'h70;
    localparam cmd_t CMD_CLEAR_STAT  = 8'h50;
    localparam cmd_t CMD_PROG_A      = 8'h40;
    localparam cmd_t CMD_PROG_B      = 8'h10;
    localparam cmd_t CMD_ERASE_ARM   = 8'h20;
    localparam cmd_t CMD_CONFIRM     = 8'hD0;
    localparam cmd_t CMD_SUSPEND     = 8'hB0;

    localparam int STAT_W     = 8;
    localparam int BIT_READY  = 7;
    localparam int BIT_SUSP   = 6;
    localparam int BIT_EERR   = 5;
    localparam int BIT_PERR   = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PGM_ARM, ST_ERS_ARM, ST_PGM_RUN,
        ST_ERS_RUN, ST_SUSP_WAIT, ST_SUSPENDED
    } ctl_state_e;

    typedef enum logic [1:0] {ENG_IDLE, ENG_RUN, ENG_SUSP} eng_state_e;

    typedef struct packed {
        logic set_both_err;
        logic clr_err;
        logic set_susp;
        logic clr_susp;
    } stat_ev_t;

    typedef struct packed {
        logic addr_le;
        logic data_le;
        logic start;
        logic resume;
    } strobe_t;

    function automatic logic is_prog_arm(input cmd_t c);
        return (c == CMD_PROG_A) || (c == CMD_PROG_B);
    endfunction

    function automatic logic state_busy(input ctl_state_e s);
        return (s == ST_PGM_RUN) || (s == ST_ERS_RUN) || (s == ST_SUSP_WAIT);
    endfunction

endpackage

// File: rtl/flash_busy_engine.sv
module flash_busy_engine
    import flash_cmd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_erase,
    input  logic [CNT_W-1:0] prog_len,
    input  logic [CNT_W-1:0] erase_len,
    input  logic             susp_req,
    input  logic             resume,
    output logic             done,
    output logic             susp_ack
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    eng_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len_sel;

    always_comb begin
        len_sel = is_erase ? erase_len : prog_len;
        if (len_sel == '0) len_sel = ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ENG_IDLE;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ENG_IDLE: if (start) begin
                    cnt <= len_sel;
                    st  <= ENG_RUN;
                end
                ENG_RUN: begin
                    if (cnt <= ONE) begin
                        done <= 1'b1;
                        st   <= ENG_IDLE;
                    end else if (susp_req) begin
                        st <= ENG_SUSP;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                ENG_SUSP: if (resume) st <= ENG_RUN;
                default: st <= ENG_IDLE;
            endcase
        end
    end

    assign susp_ack = (st == ENG_SUSP);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  cmd_t     wr_cmd,
    input  logic     eng_done,
    input  logic     eng_ack,
    output logic     rd_is_status,
    output strobe_t  strobe,
    output logic     eng_is_erase,
    output logic     eng_susp_req,
    output logic     ready,
    output stat_ev_t ev
);
    ctl_state_e st, st_n;
    logic       mode_n, erase_n, req_n;
    strobe_t    strobe_n;

    always_comb begin
        st_n     = st;
        mode_n   = rd_is_status;
        erase_n  = eng_is_erase;
        req_n    = eng_susp_req;
        strobe_n = '0;
        ev       = '0;
        case (st)
            ST_IDLE: if (wr_en) begin
                if (wr_cmd == CMD_READ_ARRAY)       mode_n = 1'b0;
                else if (wr_cmd == CMD_READ_STATUS) mode_n = 1'b1;
                else if (wr_cmd == CMD_CLEAR_STAT)  ev.clr_err = 1'b1;
                else if (wr_cmd == CMD_ERASE_ARM)   st_n = ST_ERS_ARM;
                else if (is_prog_arm(wr_cmd))       st_n = ST_PGM_ARM;
            end
            ST_PGM_ARM: if (wr_en) begin
                strobe_n.addr_le = 1'b1;
                strobe_n.data_le = 1'b1;
                strobe_n.start   = 1'b1;
                erase_n          = 1'b0;
                mode_n           = 1'b1;
                st_n             = ST_PGM_RUN;
            end
            ST_ERS_ARM: if (wr_en) begin
                mode_n = 1'b1;
                if (wr_cmd == CMD_CONFIRM) begin
                    strobe_n.addr_le = 1'b1;
                    strobe_n.start   = 1'b1;
                    erase_n          = 1'b1;
                    st_n             = ST_ERS_RUN;
                end else begin
                    ev.set_both_err = 1'b1;
                    st_n            = ST_IDLE;
                end
            end
            ST_PGM_RUN: if (eng_done) st_n = ST_IDLE;
            ST_ERS_RUN: begin
                if (eng_done) begin
                    st_n = ST_IDLE;
                end else if (wr_en && wr_cmd == CMD_SUSPEND) begin
                    req_n = 1'b1;
                    st_n  = ST_SUSP_WAIT;
                end else if (wr_en && wr_cmd == CMD_READ_STATUS) begin
                    mode_n = 1'b1;
                end
            end
            ST_SUSP_WAIT: begin
                if (eng_done) begin
                    req_n = 1'b0;
                    st_n  = ST_IDLE;
                end else if (wr_en && wr_cmd == CMD_CONFIRM) begin
                    req_n           = 1'b0;
                    strobe_n.resume = 1'b1;
                    st_n            = ST_ERS_RUN;
                end else if (eng_ack) begin
                    req_n       = 1'b0;
                    ev.set_susp = 1'b1;
                    st_n        = ST_SUSPENDED;
                end else if (wr_en && wr_cmd == CMD_READ_STATUS) begin
                    mode_n = 1'b1;
                end
            end
            ST_SUSPENDED: if (wr_en) begin
                if (wr_cmd == CMD_READ_ARRAY)       mode_n = 1'b0;
                else if (wr_cmd == CMD_READ_STATUS) mode_n = 1'b1;
                else if (wr_cmd == CMD_CONFIRM) begin
                    strobe_n.resume = 1'b1;
                    ev.clr_susp     = 1'b1;
                    mode_n          = 1'b1;
                    st_n            = ST_ERS_RUN;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            rd_is_status <= 1'b0;
            strobe       <= '0;
            eng_is_erase <= 1'b0;
            eng_susp_req <= 1'b0;
        end else begin
            st           <= st_n;
            rd_is_status <= mode_n;
            strobe       <= strobe_n;
            eng_is_erase <= erase_n;
            eng_susp_req <= req_n;
        end
    end

    assign ready = !state_busy(st);

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stat_ev_t          ev,
    input  logic              ready,
    output logic [STAT_W-1:0] status
);
    logic perr, eerr, susp;

    always_ff @(posedge clk) begin
        if (rst) begin
            perr <= 1'b0;
            eerr <= 1'b0;
            susp <= 1'b0;
        end else begin
            if (ev.set_both_err) begin
                perr <= 1'b1;
                eerr <= 1'b1;
            end else if (ev.clr_err) begin
                perr <= 1'b0;
                eerr <= 1'b0;
            end
            if (ev.set_susp)      susp <= 1'b1;
            else if (ev.clr_susp) susp <= 1'b0;
        end
    end

    always_comb begin
        status            = '0;
        status[BIT_READY] = ready;
        status[BIT_SUSP]  = susp;
        status[BIT_EERR]  = eerr;
        status[BIT_PERR]  = perr;
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_cmd,
    input  logic [CNT_W-1:0] prog_len,
    input  logic [CNT_W-1:0] erase_len,
    output logic             rd_is_status,
    output logic             addr_le,
    output logic             data_le,
    output logic             eng_start,
    output logic             eng_is_erase,
    output logic             eng_susp_req,
    output logic             eng_resume,
    output logic             eng_susp_ack,
    output logic [7:0]       status
);
    strobe_t  strobe;
    stat_ev_t ev;
    logic     ready, eng_done;

    flash_cmd_decoder u_dec (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_cmd       (wr_cmd),
        .eng_done     (eng_done),
        .eng_ack      (eng_susp_ack),
        .rd_is_status (rd_is_status),
        .strobe       (strobe),
        .eng_is_erase (eng_is_erase),
        .eng_susp_req (eng_susp_req),
        .ready        (ready),
        .ev           (ev)
    );

    flash_busy_engine #(.CNT_W(CNT_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (strobe.start),
        .is_erase  (eng_is_erase),
        .prog_len  (prog_len),
        .erase_len (erase_len),
        .susp_req  (eng_susp_req),
        .resume    (strobe.resume),
        .done      (eng_done),
        .susp_ack  (eng_susp_ack)
    );

    flash_status_reg u_stat (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .ready  (ready),
        .status (status)
    );

    assign addr_le    = strobe.addr_le;
    assign data_le    = strobe.data_le;
    assign eng_start  = strobe.start;
    assign eng_resume = strobe.resume;

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_cmd,
    input logic       rd_is_status,
    input logic       addr_le,
    input logic       data_le,
    input logic       eng_start,
    input logic       eng_resume,
    input logic       eng_susp_req,
    input logic       eng_susp_ack,
    input logic [7:0] status
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status == 8'h80) && !rd_is_status && !eng_start && !eng_susp_req);

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !status[7] && rd_is_status);

    assert_busy_no_latch_R7: assert property (@(posedge clk) disable iff (rst)
        !status[7] |=> !addr_le && !data_le && !eng_start);

    assert_susp_flag_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_susp_ack) && !(wr_en && wr_cmd == 8'hD0) |=> status[6]);

    assert_susp_ready_R9: assert property (@(posedge clk) disable iff (rst)
        status[6] |-> status[7] && !eng_susp_req);

    assert_resume_clears_R10: assert property (@(posedge clk) disable iff (rst)
        eng_resume |-> !status[6] && !status[7]);

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eng_start, eng_resume}));
endmodule

bind flash_cmd_ctrl flash_cmd_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_cmd       (wr_cmd),
    .rd_is_status (rd_is_status),
    .addr_le      (addr_le),
    .data_le      (data_le),
    .eng_start    (eng_start),
    .eng_resume   (eng_resume),
    .eng_susp_req (eng_susp_req),
    .eng_susp_ack (eng_susp_ack),
    .status       (status)
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_cmd = 8'h00;
    logic [CNT_W-1:0] prog_len = 16'd12;
    logic [CNT_W-1:0] erase_len = 16'd20;
    logic rd_is_status, addr_le, data_le, eng_start, eng_is_erase;
    logic eng_susp_req, eng_resume, eng_susp_ack;
    logic [7:0] status;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    // reference state for the randomised idle-phase model
    bit m_mode, m_perr, m_eerr;

    flash_cmd_ctrl #(.CNT_W(CNT_W)) u_flash_cmd_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .prog_len(prog_len), .erase_len(erase_len),
        .rd_is_status(rd_is_status), .addr_le(addr_le), .data_le(data_le),
        .eng_start(eng_start), .eng_is_erase(eng_is_erase),
        .eng_susp_req(eng_susp_req), .eng_resume(eng_resume),
        .eng_susp_ack(eng_susp_ack), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] c);
        @(negedge clk);
        wr_en  = 1'b1;
        wr_cmd = c;
        @(negedge clk);
        wr_en  = 1'b0;
    endtask

    task automatic wait_ready(output int edge_at);
        int guard = 0;
        while (!status[7] && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        edge_at = cyc;
    endtask

    function automatic bit is_known(input logic [7:0] c);
        return c inside {8'hFF, 8'h70, 8'h50, 8'h40, 8'h10, 8'h20, 8'hD0, 8'hB0};
    endfunction

    function automatic int exp_status(input bit eerr, input bit perr);
        return 8'h80 | (int'(eerr) << 5) | (int'(perr) << 4);
    endfunction

    initial begin
        int e, w, r, rdy, c;
        logic [7:0] b;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 status", status, 8'h80);
        chk("R1 mode", rd_is_status, 0);
        chk("R1 start", eng_start, 0);
        chk("R1 req", eng_susp_req, 0);

        wr(8'h70); chk("R2 read status", rd_is_status, 1);
        wr(8'hFF); chk("R2 read array", rd_is_status, 0);
        wr(8'h33); chk("R2 unknown", rd_is_status, 0);
        wr(8'h70);
        wr(8'hD0); chk("R10 stray resume mode", rd_is_status, 1);
        chk("R10 stray resume status", status, 8'h80);

        // program via 0x40
        wr(8'h40); chk("R3 arm no start", eng_start, 0);
        wr(8'h5A); e = cyc;
        chk("R3 addr_le", addr_le, 1);
        chk("R3 data_le", data_le, 1);
        chk("R3 start", eng_start, 1);
        chk("R3 is_erase", eng_is_erase, 0);
        chk("R3 mode", rd_is_status, 1);
        chk("R4 busy", status[7], 0);
        wr(8'hB0); chk("R4 no suspend", eng_susp_req, 0);
        wr(8'hFF); chk("R4 mode kept", rd_is_status, 1);
        wait_ready(rdy); chk("R4 program time", rdy, e + 12 + 2);

        // program via 0x10 with zero length
        prog_len = '0;
        wr(8'h10); wr(8'h00); e = cyc;
        chk("R3 alt code start", eng_start, 1);
        wait_ready(rdy); chk("R4 zero length time", rdy, e + 3);
        prog_len = 16'd12;

        // plain erase
        wr(8'h20); wr(8'hD0); e = cyc;
        chk("R5 addr_le", addr_le, 1);
        chk("R5 data_le", data_le, 0);
        chk("R5 start", eng_start, 1);
        chk("R5 is_erase", eng_is_erase, 1);
        wr(8'hFF); chk("R7 mode kept", rd_is_status, 1);
        wr(8'h40); chk("R7 no start", eng_start, 0);
        wr(8'h5A); chk("R7 no latch", addr_le | data_le, 0);
        wait_ready(rdy); chk("R5 erase time", rdy, e + 20 + 2);
        chk("R5 status", status, 8'h80);

        // failed erase sequence
        wr(8'hFF);
        wr(8'h20); wr(8'h40);
        chk("R6 status", status, 8'hB0);
        chk("R6 mode", rd_is_status, 1);
        chk("R6 no start", eng_start, 0);
        wr(8'hFF); chk("R6 next cmd", rd_is_status, 0);
        wr(8'h50); chk("R11 cleared", status, 8'h80);
        chk("R11 mode kept", rd_is_status, 0);

        // suspend / resume
        wr(8'h20); wr(8'hD0); e = cyc;
        wr(8'hB0); w = cyc;
        chk("R8 req", eng_susp_req, 1);
        @(negedge clk); chk("R8 ack", eng_susp_ack, 1);
        @(negedge clk);
        chk("R8 flag", status[6], 1);
        chk("R8 req dropped", eng_susp_req, 0);
        chk("R8 ready", status[7], 1);
        repeat (25) @(negedge clk);
        chk("R9 still frozen", eng_susp_ack, 1);
        wr(8'hFF); chk("R9 array", rd_is_status, 0);
        wr(8'h40); chk("R9 ignored mode", rd_is_status, 0);
        chk("R9 ignored start", eng_start | data_le, 0);
        wr(8'h70); chk("R9 status", rd_is_status, 1);
        wr(8'hD0); r = cyc;
        chk("R10 resume", eng_resume, 1);
        chk("R10 flag clear", status[6], 0);
        chk("R10 busy", status[7], 0);
        c = 20 - (w - e - 1);
        wait_ready(rdy); chk("R10 remaining time", rdy, r + c + 2);

        // reset during erase
        wr(8'h20); wr(8'hD0);
        repeat (3) @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        chk("R12 status", status, 8'h80);
        chk("R12 mode", rd_is_status, 0);
        chk("R12 ack", eng_susp_ack, 0);
        wr(8'h40); wr(8'h11); chk("R12 new program", eng_start, 1);
        wait_ready(rdy);

        // randomised idle-phase commands against a bench model
        wr(8'h50); wr(8'hFF);
        m_mode = 0; m_perr = 0; m_eerr = 0;
        for (int i = 0; i < 200; i++) begin
            int k = $urandom % 6;
            case (k)
                0: begin wr(8'hFF); m_mode = 0; end
                1: begin wr(8'h70); m_mode = 1; end
                2: begin wr(8'h50); m_perr = 0; m_eerr = 0; end
                3: begin
                    b = 8'($urandom);
                    if (b == 8'hD0) b = 8'h00;
                    wr(8'h20); wr(b);
                    m_mode = 1; m_perr = 1; m_eerr = 1;
                end
                4: begin
                    b = 8'($urandom);
                    while (is_known(b)) b = 8'($urandom);
                    wr(b);
                end
                default: wr(8'hD0);
            endcase
            chk("R2/R6/R11 random mode", rd_is_status, int'(m_mode));
            chk("R2/R6/R11 random status", status, exp_status(m_eerr, m_perr));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule